// File: doc/BRIEF.md
# Pin-Gated Master Control Register

This block holds the 16-bit master control word of a serial bus terminal and merges it with external pins to drive the terminal's global controls. A host reaches it through a plain synchronous port. A write updates the register at the clock edge, and a read returns it combinationally when the address selects offset 0x0000. Bit 15 and bit 14 are transmit inhibits for bus A and bus B. Each is OR-combined at once with its own inhibit pin. Bit 12 enables the bus controller. It is AND-combined with a controller-enable pin, which is first passed through a two-flop synchroniser.

Bit 13 is a start strobe. It is never stored. A write that carries it, with the enable bit and the synchronised pin both high, issues a single-cycle start pulse and marks the controller as running. A controller-done input ends the run. If the effective enable drops while the controller is running, an abort output rises in that same cycle. The three soft-reset strobes for the other terminal functions are accepted but leave the register untouched. Only the hard reset clears it.

Top module: `mcfg_master_ctl`

## Requirements
- R1: While `rst_ni` is low, every stored bit is 0. After reset, with the address at 0x0000, `rdata_o` reads 0x0000 and `ctl_start_o`, `ctl_abort_o` and `ctl_en_o` are 0.
- R2: A write to address 0x0000 stores bits 15, 14 and 11..0 exactly as written, including bits with no function. A read of address 0x0000 returns them. Any other address reads 0x0000, and a write to it changes nothing.
- R3: Asserting `mt_srst_i`, `rt1_srst_i` or `rt2_srst_i` leaves the stored register value unchanged.
- R4: `inh_a_o` equals stored bit 15 OR `inh_a_pin_i`, with no clock delay.
- R5: `inh_b_o` equals stored bit 14 OR `inh_b_pin_i`, with no clock delay.
- R6: `ctl_en_o` equals stored bit 12 AND `ctl_en_pin_i` delayed through two flops.
- R7: A write of 1 to bit 12 while the synchronised enable pin is 0 stores 0 in bit 12.
- R8: Bit 13 always reads 0. In the cycle after a write with bit 13 = 1, `ctl_start_o` is high for exactly one cycle if the new bit 12 and the synchronised pin are both 1. Otherwise it stays low.
- R9: One write that sets bit 12 and bit 13 together, with the synchronised pin high, enables the controller and starts it in the same cycle.
- R10: A start sets a running state. `ctl_done_i` or an abort clears it. `ctl_abort_o` is never high unless the controller is running.
- R11: While the controller is running, `ctl_abort_o` is high in the same cycle that `ctl_en_o` is 0. It is high for one cycle, after which the controller is no longer running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard master reset, active low, asynchronous |
| mt_srst_i | input | 1 | Monitor soft-reset strobe (no effect here) |
| rt1_srst_i | input | 1 | Terminal 1 soft-reset strobe (no effect here) |
| rt2_srst_i | input | 1 | Terminal 2 soft-reset strobe (no effect here) |
| addr_i | input | 4 | Host register address |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| inh_a_pin_i | input | 1 | Bus A transmit-inhibit pin |
| inh_b_pin_i | input | 1 | Bus B transmit-inhibit pin |
| ctl_en_pin_i | input | 1 | Controller-enable pin (asynchronous) |
| ctl_done_i | input | 1 | Controller finished its run |
| inh_a_o | output | 1 | Effective bus A inhibit |
| inh_b_o | output | 1 | Effective bus B inhibit |
| ctl_en_o | output | 1 | Effective controller enable |
| ctl_start_o | output | 1 | One-cycle controller start pulse |
| ctl_abort_o | output | 1 | Immediate controller abort |

## Verification
Some properties are checked on every cycle. Bit 13 always reads back 0. An asserted inhibit pin always forces its inhibit output high. A start pulse only ever appears with bit 12 stored high. An abort only appears while the controller is running, and the running state is gone one cycle after it. Other checks need a planned sequence and come from the bench scenarios:
- the gating of a bit 12 write against the synchronised pin;
- the two-cycle delay of the enable pin;
- a combined bit 12 and bit 13 write;
- the inertness of the soft-reset strobes and of off-address writes;
- an abort raised by a falling pin, as opposed to one raised by a host write.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned BIT_IA  = 15;
  localparam int unsigned BIT_IB  = 14;
  localparam int unsigned BIT_GO  = 13;
  localparam int unsigned BIT_EN  = 12;

  typedef enum logic {RUN_IDLE = 1'b0, RUN_BUSY = 1'b1} run_e;
endpackage

// File: rtl/mcfg_sync.sv
module mcfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcfg_store.sv
module mcfg_store
  import mcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mt_srst_i,
  input  logic              rt1_srst_i,
  input  logic              rt2_srst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_pin_s_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              go_req_o
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

  logic              hit;
  logic [DATA_W-1:0] cfg_q, cfg_d;

  assign hit = wr_i && (addr_i == SEL);

  always_comb begin
    cfg_d = cfg_q;
    if (hit) begin
      cfg_d         = wdata_i;
      cfg_d[BIT_GO] = 1'b0;                          // strobe, never stored
      cfg_d[BIT_EN] = wdata_i[BIT_EN] & en_pin_s_i;  // cannot set while pin low
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;

  // enable is resolved before start within the same write
  assign go_req_o = hit && wdata_i[BIT_GO] && cfg_d[BIT_EN] && en_pin_s_i;
  assign cfg_o    = cfg_q;
  assign rdata_o  = (addr_i == SEL) ? cfg_q : '0;

  p_go_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BIT_GO] == 1'b0);

  p_soft_reset_inert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mt_srst_i || rt1_srst_i || rt2_srst_i) && !hit) |=> $stable(cfg_q));

  p_en_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !en_pin_s_i) |=> !cfg_q[BIT_EN]);
endmodule

// File: rtl/mcfg_seq.sv
module mcfg_seq
  import mcfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_req_i,
  input  logic en_eff_i,
  input  logic done_i,
  output logic start_o,
  output logic abort_o
);
  run_e run_q;
  logic start_q;

  // abort is combinational so it is seen in the cycle the enable drops
  assign abort_o = (run_q == RUN_BUSY) && !en_eff_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q   <= RUN_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= go_req_i;
      if (go_req_i)                run_q <= RUN_BUSY;
      else if (abort_o || done_i)  run_q <= RUN_IDLE;
    end

  assign start_o = start_q;

  p_abort_needs_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (run_q == RUN_BUSY));

  p_abort_ends_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !go_req_i) |=> (run_q == RUN_IDLE));

  p_start_sets_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (run_q == RUN_BUSY));
endmodule

// File: rtl/mcfg_master_ctl.sv
module mcfg_master_ctl
  import mcfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned REG_ADDR    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mt_srst_i,
  input  logic              rt1_srst_i,
  input  logic              rt2_srst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              inh_a_pin_i,
  input  logic              inh_b_pin_i,
  input  logic              ctl_en_pin_i,
  input  logic              ctl_done_i,
  output logic              inh_a_o,
  output logic              inh_b_o,
  output logic              ctl_en_o,
  output logic              ctl_start_o,
  output logic              ctl_abort_o
);
  logic              en_pin_s;
  logic              go_req;
  logic [DATA_W-1:0] cfg;

  mcfg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_en_pin_i),
    .q_o   (en_pin_s)
  );

  mcfg_store #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mt_srst_i (mt_srst_i),
    .rt1_srst_i(rt1_srst_i),
    .rt2_srst_i(rt2_srst_i),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .en_pin_s_i(en_pin_s),
    .rdata_o   (rdata_o),
    .cfg_o     (cfg),
    .go_req_o  (go_req)
  );

  assign inh_a_o  = cfg[BIT_IA] | inh_a_pin_i;
  assign inh_b_o  = cfg[BIT_IB] | inh_b_pin_i;
  assign ctl_en_o = cfg[BIT_EN] & en_pin_s;

  mcfg_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_req_i(go_req),
    .en_eff_i(ctl_en_o),
    .done_i  (ctl_done_i),
    .start_o (ctl_start_o),
    .abort_o (ctl_abort_o)
  );

  p_inh_a_pin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_a_pin_i |-> inh_a_o);

  p_inh_b_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_b_pin_i |-> inh_b_o);

  p_start_with_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start_o |-> cfg[BIT_EN]);

  p_en_needs_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en_o |-> en_pin_s);
endmodule

// File: tb/mcfg_master_ctl_tb.sv
`timescale 1ns/1ps
module mcfg_master_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mt_s = 0, rt1_s = 0, rt2_s = 0;
  logic [3:0] addr = '0;
  logic wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic pa = 0, pb = 0, pen = 0, done = 0;
  logic inh_a, inh_b, en, start, abort_w;

  int checks = 0, failures = 0;
  int n_start = 0, n_abort = 0;

  always #2 clk = ~clk;

  mcfg_master_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mt_srst_i(mt_s), .rt1_srst_i(rt1_s), .rt2_srst_i(rt2_s),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .inh_a_pin_i(pa), .inh_b_pin_i(pb), .ctl_en_pin_i(pen), .ctl_done_i(done),
    .inh_a_o(inh_a), .inh_b_o(inh_b), .ctl_en_o(en),
    .ctl_start_o(start), .ctl_abort_o(abort_w)
  );

  // behavioural reference
  logic m_s1 = 0, m_s2 = 0, m_start = 0, m_run = 0;
  logic [15:0] m_reg = '0;

  function automatic logic m_en();
    return m_reg[12] & m_s2;
  endfunction
  function automatic logic m_abort();
    return m_run & ~m_en();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_start = 0; m_run = 0; m_reg = '0;
    end else begin
      logic [15:0] nreg;
      logic nstart, hit, ab;
      hit = wr && addr == 4'd0;
      ab = m_abort();
      nreg = m_reg;
      if (hit) begin
        nreg = wdata;
        nreg[13] = 1'b0;
        nreg[12] = wdata[12] & m_s2;
      end
      nstart = hit && wdata[13] && nreg[12] && m_s2;
      if (nstart) m_run = 1;
      else if (ab || done) m_run = 0;
      m_reg = nreg; m_start = nstart;
      m_s2 = m_s1; m_s1 = pen;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] er;
    er = (addr == 4'd0) ? m_reg : 16'h0;
    chk(rdata === er, "R2 rdata", rdata, er);
    chk(inh_a === (m_reg[15] | pa), "R4 inh_a", {15'b0, inh_a}, {15'b0, m_reg[15] | pa});
    chk(inh_b === (m_reg[14] | pb), "R5 inh_b", {15'b0, inh_b}, {15'b0, m_reg[14] | pb});
    chk(en === m_en(), "R6 en", {15'b0, en}, {15'b0, m_en()});
    chk(start === m_start, "R8 start", {15'b0, start}, {15'b0, m_start});
    chk(abort_w === m_abort(), "R11 abort", {15'b0, abort_w}, {15'b0, m_abort()});
    if (start === 1'b1) n_start++;
    if (abort_w === 1'b1) n_abort++;
  endtask

  // inputs already set after a negedge; compare, then advance one cycle
  task automatic step();
    #1 compare();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1;
    step();
    wr = 0; addr = 4'd0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    #1 chk(rdata === 16'h0, "R1 reset rdata", rdata, 16'h0);
    chk({start, abort_w, en} === 3'b000, "R1 reset ctl", {13'b0, start, abort_w, en}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    idle(2);

    // R7: enable pin low, bit 12 cannot be set; undefined bits kept (R2)
    wr_reg(4'd0, 16'hFFFF);
    #1 chk(rdata === 16'hCFFF, "R7 gated write", rdata, 16'hCFFF);
    idle(1);

    // R4/R5: pins toggle with register bits cleared
    wr_reg(4'd0, 16'h0A5A);
    pa = 1; step(); pb = 1; step(); pa = 0; step(); pb = 0; step();
    // R2: off-address write ignored
    wr_reg(4'd3, 16'hFFFF);
    #1 chk(rdata === 16'h0A5A, "R2 off-address", rdata, 16'h0A5A);
    addr = 4'd5; step(); addr = 4'd0;

    // R6: pin rises, two-cycle sync
    pen = 1; step(); idle(3);
    wr_reg(4'd0, 16'h1000);
    idle(1);
    // R8: separate start write, 13 reads 0
    wr_reg(4'd0, 16'h3000);
    #1 chk(start === 1'b1, "R8 start pulse", {15'b0, start}, 16'h1);
    chk(rdata === 16'h1000, "R8 bit13 reads zero", rdata, 16'h1000);
    idle(2);
    // R10: done clears run; then dropping bit 12 gives no abort
    done = 1; step(); done = 0;
    wr_reg(4'd0, 16'h0000);
    #1 chk(abort_w === 1'b0, "R10 no abort when idle", {15'b0, abort_w}, 16'h0);
    idle(2);

    // R9: combined set of 12 and 13
    wr_reg(4'd0, 16'h3000);
    #1 chk(start === 1'b1 && en === 1'b1, "R9 combined start", {14'b0, start, en}, 16'h3);
    idle(2);
    // R3: soft resets while running
    mt_s = 1; step(); mt_s = 0; rt1_s = 1; step(); rt1_s = 0; rt2_s = 1; step(); rt2_s = 0;
    #1 chk(rdata === 16'h1000, "R3 soft resets inert", rdata, 16'h1000);
    // R11: pin drops while running -> abort after sync delay
    pen = 0; idle(4);
    chk(n_abort == 1, "R11 one abort from pin", 16'(n_abort), 16'h1);

    // host write clearing bit 12 during a run
    pen = 1; idle(3);
    wr_reg(4'd0, 16'hB000);
    idle(1);
    wr_reg(4'd0, 16'h8000);
    idle(2);
    chk(n_abort == 2, "R11 abort from write", 16'(n_abort), 16'h2);
    chk(n_start == 3, "R8 start count", 16'(n_start), 16'h3);

    // R7: write with 12 and 13 while pin low gives no start
    pen = 0; idle(3);
    wr_reg(4'd0, 16'h3000);
    #1 chk(start === 1'b0 && rdata === 16'h0, "R7 no start pin low", {start, rdata[14:0]}, 16'h0);
    idle(1);

    // R1: hard reset mid-operation
    wr_reg(4'd0, 16'hC123);
    rst_n = 0; #1;
    chk(rdata === 16'h0, "R1 hard reset", rdata, 16'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule